// File: doc/BRIEF.md
# Layered Test-Pattern Pixel Generator

This block emits one 16-bit pixel word for every rising edge of a sample strobe, so that a downstream acquisition chain can be exercised with a pattern that is known ahead of time. Each word is built in layers. The base is an up/down counter. A 3-bit pseudo-random field can replace the lowest bits. A single chosen bit can then be forced to 0 or 1. Finally, a fixed 4-bit value can replace the top nibble. Every layer is switched on by a static configuration input, and any of those inputs may change while strobes keep arriving.

No external counter reset is assumed to exist between frames. An inactivity timer therefore clears the counter once the strobe has been quiet for a programmable number of seconds, so that the next frame starts at zero. The strobe and all configuration inputs are asynchronous to the system clock. They pass through synchronizer flops, and the strobe is edge-detected inside the block.

Top module: `pattern_pixel_gen`

## Requirements
- R1: While reset is asserted and directly after it, `pixel_o` is 0x0000 and `pixel_valid_o` is 0. The counter starts at zero, so the first pixel with only counting enabled is 0x0000.
- R2: Each rising edge of `sample_strobe_i` yields exactly one `pixel_valid_o` pulse, one clock long. `pixel_o` carries the counter value held before that strobe's step and keeps its value between pulses.
- R3: With counting on, forcing off and `shared_val_i`=0, the counter rises by one per pixel and wraps from 0xFFFF to 0x0000.
- R4: With counting on, forcing off and `shared_val_i`=1, the counter falls by one per pixel and wraps from 0x0000 to 0xFFFF.
- R5: With `cnt_en_i`=0 the counter holds its value, so bits not covered by another layer repeat from pixel to pixel.
- R6: With `noise_en_i`=1, bits [2:0] come from a free-running pseudo-random source and vary from pixel to pixel, while bits [15:3] are unaffected.
- R7: With `force_en_i`=1, bit number `force_pos_i` (a binary index from 0 to 15) of the pixel equals `shared_val_i`. This overrides both the counter and the noise field. While forcing is on, the counter counts up.
- R8: With `ofs_en_i`=1, bits [15:12] equal `ofs_val_i`. This overrides every other layer, including a forced bit in that nibble.
- R9: With `idle_en_i`=1 and `idle_short_i`=1, the counter clears to zero once no strobe has arrived for 2×CLK_HZ clock cycles. The clear happens exactly once per gap.
- R10: With `idle_en_i`=1 and `idle_short_i`=0, the timeout is 4×CLK_HZ cycles. A gap longer than the short delay but shorter than the long delay leaves the counter unchanged.
- R11: With `idle_en_i`=0, no gap clears the counter.
- R12: A configuration change made while running applies to the pixels that follow it, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_strobe_i | input | 1 | Asynchronous pixel strobe; each rising edge produces one pixel |
| ofs_en_i | input | 1 | Enable the top-nibble offset |
| ofs_val_i | input | 4 | Offset value placed on bits [15:12] |
| cnt_en_i | input | 1 | Enable counter stepping |
| noise_en_i | input | 1 | Enable the noise field on bits [2:0] |
| idle_en_i | input | 1 | Enable the inactivity clear of the counter |
| idle_short_i | input | 1 | 1 selects the 2 s timeout, 0 selects the 4 s timeout |
| force_en_i | input | 1 | Enable forcing of one bit |
| shared_val_i | input | 1 | Forced value when forcing is on; count direction (1 = down) when forcing is off |
| force_pos_i | input | 4 | Index of the bit to force |
| pixel_o | output | 16 | Registered pixel word |
| pixel_valid_o | output | 1 | One-cycle pulse marking a new pixel |

## Verification
Directed sequences separate up-counting from down-counting, including the wrap in each direction. They also set layers against each other in overlapping bit positions: a forced bit inside the offset nibble, and a forced bit inside the noise field. This shows that the overlay order is fixed and does not depend on which layers happen to be enabled. The inactivity tests use gaps that fall between the short and the long timeout, so that a swapped delay select is distinguished from a working one. A long gap with the timer disabled confirms that nothing else clears the counter. Random configurations, changed between bursts of strobes without any reset, are compared against a bench model with the noise bits masked out. This catches layering errors that only appear in particular combinations.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
  localparam int PIX_W   = 16;
  localparam int OFS_W   = 4;
  localparam int NOISE_W = 3;
  localparam int POS_W   = $clog2(PIX_W);

  typedef struct packed {
    logic             ofs_en;
    logic [OFS_W-1:0] ofs_val;
    logic             cnt_en;
    logic             noise_en;
    logic             idle_en;
    logic             idle_short;
    logic             force_en;
    logic             shared_val;
    logic [POS_W-1:0] force_pos;
  } pxg_cfg_t;

  localparam int CFG_W = $bits(pxg_cfg_t);

  // Layer order, lowest first: counter, noise, forced bit, offset.
  function automatic logic [PIX_W-1:0] pxg_compose(
    input logic [PIX_W-1:0]   cnt,
    input logic [NOISE_W-1:0] nz,
    input pxg_cfg_t           c
  );
    logic [PIX_W-1:0] w;
    w = cnt;
    if (c.noise_en) w[NOISE_W-1:0] = nz;
    if (c.force_en) w[c.force_pos] = c.shared_val;
    if (c.ofs_en)   w[PIX_W-1 -: OFS_W] = c.ofs_val;
    return w;
  endfunction
endpackage

// File: rtl/pxg_sync.sv
module pxg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pxg_lfsr.sv
module pxg_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  logic [W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst)            lfsr_q <= SEED;
    else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
    else                lfsr_q <= lfsr_q >> 1;
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/pxg_idle_timer.sv
module pxg_idle_timer #(
  parameter int unsigned SHORT_CYC = 2,
  parameter int unsigned LONG_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic enable_i,
  input  logic short_sel_i,
  output logic clear_o
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC);

  logic [CW-1:0] gap_q;
  logic          fired_q;
  logic          hit;

  assign hit     = gap_q >= (short_sel_i ? SHORT_LIM : LONG_LIM);
  assign clear_o = enable_i && hit && !fired_q && !restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      fired_q <= 1'b0;
    end else if (restart_i) begin
      gap_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (gap_q != LONG_LIM) gap_q <= gap_q + 1'b1;
      if (clear_o) fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pattern_pixel_gen.sv
module pattern_pixel_gen
  import pxg_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned SHORT_SEC   = 2,
  parameter int unsigned LONG_SEC    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sample_strobe_i,
  input  logic        ofs_en_i,
  input  logic [3:0]  ofs_val_i,
  input  logic        cnt_en_i,
  input  logic        noise_en_i,
  input  logic        idle_en_i,
  input  logic        idle_short_i,
  input  logic        force_en_i,
  input  logic        shared_val_i,
  input  logic [3:0]  force_pos_i,
  output logic [15:0] pixel_o,
  output logic        pixel_valid_o
);
  localparam int unsigned SHORT_CYC = CLK_HZ * SHORT_SEC;
  localparam int unsigned LONG_CYC  = CLK_HZ * LONG_SEC;

  pxg_cfg_t         cfg_raw, cfg_s;
  logic             strb_s, strb_d, adv, dir_down, idle_clr;
  logic [PIX_W-1:0] cnt_q, pix_q, lfsr_state;
  logic             vld_q;

  assign cfg_raw = '{ofs_en: ofs_en_i, ofs_val: ofs_val_i, cnt_en: cnt_en_i,
                     noise_en: noise_en_i, idle_en: idle_en_i,
                     idle_short: idle_short_i, force_en: force_en_i,
                     shared_val: shared_val_i, force_pos: force_pos_i};

  pxg_sync #(.W(CFG_W + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({sample_strobe_i, cfg_raw}),
    .q({strb_s, cfg_s})
  );

  always_ff @(posedge clk) begin
    if (rst) strb_d <= 1'b0;
    else     strb_d <= strb_s;
  end
  assign adv = strb_s && !strb_d;

  pxg_lfsr #(.W(PIX_W), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state_o(lfsr_state)
  );

  pxg_idle_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_idle (
    .clk(clk), .rst(rst), .restart_i(adv),
    .enable_i(cfg_s.idle_en), .short_sel_i(cfg_s.idle_short),
    .clear_o(idle_clr)
  );

  // The shared input sets the direction only while forcing is off.
  assign dir_down = !cfg_s.force_en && cfg_s.shared_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (cfg_s.cnt_en) cnt_q <= dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end else if (idle_clr) begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= adv;
      if (adv) pix_q <= pxg_compose(cnt_q, lfsr_state[NOISE_W-1:0], cfg_s);
    end
  end

  assign pixel_o       = pix_q;
  assign pixel_valid_o = vld_q;
endmodule

// File: rtl/pxg_checker.sv
module pxg_checker
  import pxg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input pxg_cfg_t         cfg,
  input logic [PIX_W-1:0] cnt,
  input logic             idle_clr,
  input logic [PIX_W-1:0] pixel,
  input logic             valid
);
  pxg_cfg_t cfg_d;
  always_ff @(posedge clk) cfg_d <= cfg;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (pixel == '0 && !valid));

  assert_valid_follows_edge_R2: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(adv));

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_pixel_held_R2: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(pixel));

  assert_offset_nibble_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && cfg_d.ofs_en) |-> (pixel[PIX_W-1 -: OFS_W] == cfg_d.ofs_val));

  assert_forced_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && cfg_d.force_en && !(cfg_d.ofs_en && cfg_d.force_pos >= POS_W'(PIX_W - OFS_W)))
      |-> (pixel[cfg_d.force_pos] == cfg_d.shared_val));

  assert_clear_once_R9: assert property (@(posedge clk) disable iff (rst)
    idle_clr |=> !idle_clr);

  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (rst)
    idle_clr |=> (cnt == '0));

  assert_clear_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    idle_clr |-> cfg.idle_en);
endmodule

bind pattern_pixel_gen pxg_checker u_chk (
  .clk(clk), .rst(rst), .adv(adv), .cfg(cfg_s), .cnt(cnt_q),
  .idle_clr(idle_clr), .pixel(pixel_o), .valid(pixel_valid_o)
);

// File: tb/pattern_pixel_gen_test.sv
`timescale 1ns/1ps
module pattern_pixel_gen_test;
  localparam int unsigned HZ = 500;  // short gap 1000 cycles, long 2000

  logic clk = 1'b0, rst = 1'b1;
  logic strobe = 0, ofs_en = 0, cnt_en = 1, noise_en = 0, idle_en = 0;
  logic idle_short = 0, force_en = 0, shared_val = 0;
  logic [3:0] ofs_val = 0, force_pos = 0;
  logic [15:0] pixel;
  logic valid;

  int checks = 0, errors = 0, vcount = 0;
  logic [15:0] exp_cnt = 0;

  always #2 clk = ~clk;

  pattern_pixel_gen #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst(rst), .sample_strobe_i(strobe),
    .ofs_en_i(ofs_en), .ofs_val_i(ofs_val), .cnt_en_i(cnt_en),
    .noise_en_i(noise_en), .idle_en_i(idle_en), .idle_short_i(idle_short),
    .force_en_i(force_en), .shared_val_i(shared_val), .force_pos_i(force_pos),
    .pixel_o(pixel), .pixel_valid_o(valid)
  );

  always @(negedge clk) if (valid) vcount++;

  function automatic logic [15:0] model(input logic [15:0] c);
    logic [15:0] w;
    w = c;
    if (force_en) w[force_pos] = shared_val;
    if (ofs_en)   w[15:12] = ofs_val;
    return w;
  endfunction

  function automatic logic [15:0] care_mask();
    logic [15:0] m;
    m = 16'hFFFF;
    if (noise_en) m[2:0] = 3'b000;
    if (force_en && force_pos < 4'd3) m[force_pos] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                       input logic [15:0] m);
    checks++;
    if ((act & m) !== (exp & m)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, m);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // One strobe; checks pixel against model and advances the model counter.
  task automatic pulse(input string req, input bit do_check);
    logic [15:0] e, m;
    int v0;
    e = model(exp_cnt);
    m = care_mask();
    v0 = vcount;
    @(negedge clk) strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    if (do_check) begin
      check(req, pixel, e, m);
      check("R2 valid count", 16'(vcount - v0), 16'd1, 16'hFFFF);
    end
    if (cnt_en) exp_cnt = (!force_en && shared_val) ? exp_cnt - 1 : exp_cnt + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd20240));
    repeat (5) @(negedge clk);
    check("R1 reset pixel", pixel, 16'h0000, 16'hFFFF);
    check("R1 reset valid", 16'(valid), 16'h0, 16'hFFFF);
    rst = 1'b0;
    settle();
    check("R1 after reset valid", 16'(valid), 16'h0, 16'hFFFF);

    // R1 and R3: counting up from zero
    for (int i = 0; i < 4; i++) pulse("R1 R3 count up", 1);

    // R4: count down through zero
    shared_val = 1; settle();
    for (int i = 0; i < 8; i++) pulse("R4 count down wrap", 1);
    // R3: up-wrap, counter now near 0xFFFC
    shared_val = 0; settle();
    for (int i = 0; i < 6; i++) pulse("R3 count up wrap", 1);

    // R5: counter held
    cnt_en = 0; settle();
    for (int i = 0; i < 3; i++) pulse("R5 hold", 1);
    cnt_en = 1; settle();

    // R6: noise varies, upper bits intact
    noise_en = 1; cnt_en = 0; settle();
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      pulse("R6 noise upper bits", 1);
      seen |= 1 << pixel[2:0];
    end
    check("R6 noise distinct values", 16'($countones(seen[7:0]) >= 3), 16'd1, 16'hFFFF);

    // R7: forced bit inside the noise field and above it; counter counts up
    force_en = 1; force_pos = 4'd1; shared_val = 1; cnt_en = 1; settle();
    for (int i = 0; i < 4; i++) pulse("R7 force in noise field", 1);
    noise_en = 0; force_pos = 4'd10; shared_val = 1; settle();
    for (int i = 0; i < 4; i++) pulse("R7 force bit 10 up", 1);
    shared_val = 0; force_pos = 4'd0; settle();
    for (int i = 0; i < 3; i++) pulse("R7 force bit 0 low", 1);

    // R8: offset beats a forced bit in the top nibble
    ofs_en = 1; ofs_val = 4'h3; force_pos = 4'd13; shared_val = 0; settle();
    for (int i = 0; i < 3; i++) pulse("R8 offset over force", 1);
    force_en = 0; ofs_val = 4'hA; settle();
    for (int i = 0; i < 3; i++) pulse("R8 offset nibble", 1);
    ofs_en = 0; settle();

    // R12: random configurations on the fly
    for (int blk = 0; blk < 15; blk++) begin
      {ofs_en, cnt_en, noise_en, force_en, shared_val} = 5'($urandom);
      ofs_val = 4'($urandom); force_pos = 4'($urandom);
      settle();
      for (int i = 0; i < 10; i++) pulse("R12 random config", 1);
    end
    {ofs_en, noise_en, force_en, shared_val} = 4'b0; cnt_en = 1; settle();
    pulse("R12 back to plain count", 1);

    // R9: short timeout clears
    idle_en = 1; idle_short = 1; settle();
    pulse("R9 before gap", 1);
    repeat (1100) @(negedge clk);
    exp_cnt = 16'h0000;
    pulse("R9 cleared after short gap", 1);
    pulse("R9 counting resumes", 1);

    // R10: long timeout
    idle_short = 0; settle();
    pulse("R10 before gap", 1);
    repeat (1300) @(negedge clk);
    pulse("R10 not cleared by mid gap", 1);
    repeat (2100) @(negedge clk);
    exp_cnt = 16'h0000;
    pulse("R10 cleared after long gap", 1);

    // R11: disabled timer
    pulse("R11 step", 1);
    idle_en = 0; settle();
    repeat (2200) @(negedge clk);
    pulse("R11 no clear when disabled", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule